// File: doc/BRIEF.md
# Pipelined No-Idle Burst SRAM

This block is a synthesizable behavioural model of a synchronous pipelined static RAM. It can switch between reads and writes on consecutive cycles with no idle cycles in between. Every command is sampled on a rising clock edge. A command either loads an external address or advances a 2-bit burst counter. Read data comes out of a pipeline two rising edges after its address cycle. Write data is taken two rising edges after its address cycle. Because reads and writes sit at the same pipeline depth, a read always sees every write issued before it.

A small state machine tracks the burst in progress. Its states are `ST_DESEL` (nothing selected), `ST_RD` (read burst) and `ST_WR` (write burst).

The transitions are:
- **load-read**: the advance input is low, the chip is selected and the read/write select is high. The machine enters `ST_RD`.
- **load-write**: the same, with the read/write select low. The machine enters `ST_WR`.
- **deselect**: the advance input is low and the chip select is high. The machine enters `ST_DESEL`.
- **continue**: the advance input is high. The machine stays in its state; from a burst state, the counter steps.
- **sleep-force**: the synchronized sleep input is active. The machine enters `ST_DESEL`.

A low-active clock enable freezes every register.

There are no bidirectional pads. Data in and data out are separate buses, and an output-valid flag stands in for the high-impedance state.

Top module: `nwb_sram`

## Requirements
- R1: After reset `rvalid` is 0, `rdata` is 0, and the state is deselected. An advance cycle issued then performs no access.
- R2: A read whose address is sampled at edge N shows its word on `rdata`, with `rvalid` high, after edge N+2. This holds when the clock enable stays low and the output is enabled.
- R3: A write whose address is sampled at edge N stores `wdata` as sampled at edge N+2. Byte write enable bit i, active low, guards `wdata[9i+8:9i]`. All enables high is a write abort: no lane changes, but the cycle is still used.
- R4: With `burst_ilv`=1, the burst beats use low address bits equal to the loaded low bits XOR 0,1,2,3. The upper bits are fixed.
- R5: With `burst_ilv`=0, the low two address bits count up from the loaded value and wrap modulo 4. The upper bits are fixed.
- R6: An advance cycle keeps the read or write type of the burst that began it, whatever `wr_n` is. An advance cycle in the deselected state performs no access.
- R7: A load cycle with `cs_n`=1 deselects. It neither reads nor writes.
- R8: With `cke_n`=1, all inputs are ignored. The pipeline, the burst counter, the output register and the write-data sampling all hold.
- R9: Read, write, read to one address on consecutive cycles needs no idle cycle. Each read returns the data of every write issued before it.
- R10: `sleep` is synchronized through two edges. Once it takes effect, commands are ignored and `rvalid` is 0. After `sleep` is deasserted, commands are accepted again from the second edge on.
- R11: `rvalid` is high only when the output register holds read data, `oe_n`=0 and `sleep`=0. `oe_n` and `sleep` act without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| cs_n | input | 1 | Combined chip select, active low, sampled on load cycles |
| adv | input | 1 | 1 = continue the burst, 0 = load an external address |
| wr_n | input | 1 | 0 = write, 1 = read on load cycles |
| be_n | input | LANES | Byte write enables, active low |
| burst_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down request |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid | output | 1 | Read data is driven |

## Verification
On every cycle, the assertions check the following:
- the freeze of state and output under a stall;
- that a deselecting load issues nothing;
- that a write burst keeps writing on advance cycles;
- the counter step;
- the two-edge read latency inside the pipeline.

Only the bench's scenarios can show the rest:
- the actual burst address orders;
- the byte-lane merge and write-abort results;
- read-after-write coherence;
- the sleep entry and exit delays;
- the output-enable gating.

The bench shows these by comparing every cycle's output against a reference array.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2
    } burst_st_e;

    // Low address bits of a burst beat: XOR order or wrapping count-up order.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/nwb_sleep_sync.sv
module nwb_sleep_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sleep;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], sleep};
            end
        end
    endgenerate

    assign asleep = sync_q[STAGES-1];
endmodule

// File: rtl/nwb_ctrl.sv
module nwb_ctrl #(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             asleep,
    input  logic             cs_n,
    input  logic             adv,
    input  logic             wr_n,
    input  logic [LANES-1:0] be_n,
    input  logic             burst_ilv,
    input  logic [AW-1:0]    addr,
    output logic             op_vld_q,
    output logic             op_wr_q,
    output logic [AW-1:0]    op_addr_q,
    output logic [LANES-1:0] op_mask_q
);
    import nwb_pkg::*;

    burst_st_e        state_q, state_d;
    logic [AW-1:0]    base_q, base_d;
    logic [1:0]       cnt_q, cnt_d;
    logic             vld_d, wr_d;
    logic [AW-1:0]    a_d;
    logic [LANES-1:0] mask_d;
    logic [1:0]       step_cnt;

    assign step_cnt = cnt_q + 2'd1;

    // Next-state and next-operation decode
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        vld_d   = 1'b0;
        wr_d    = 1'b0;
        a_d     = op_addr_q;
        mask_d  = '0;
        if (asleep) begin
            state_d = ST_DESEL;                    // sleep-force
        end else if (!adv) begin
            if (cs_n) begin
                state_d = ST_DESEL;                // deselect
            end else begin
                base_d  = addr;                    // load-read / load-write
                cnt_d   = 2'd0;
                state_d = wr_n ? ST_RD : ST_WR;
                vld_d   = 1'b1;
                wr_d    = !wr_n;
                a_d     = addr;
                mask_d  = wr_n ? '0 : ~be_n;
            end
        end else begin
            unique case (state_q)
                ST_DESEL: ;                        // continue with nothing selected
                ST_RD, ST_WR: begin                // continue
                    cnt_d  = step_cnt;
                    vld_d  = 1'b1;
                    wr_d   = (state_q == ST_WR);
                    a_d    = {base_q[AW-1:2], burst_lo(base_q[1:0], step_cnt, burst_ilv)};
                    mask_d = (state_q == ST_WR) ? ~be_n : '0;
                end
                default: state_d = ST_DESEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (!cke_n) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // Issued-operation register (pipeline stage one)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_vld_q  <= 1'b0;
            op_wr_q   <= 1'b0;
            op_addr_q <= '0;
            op_mask_q <= '0;
        end else if (!cke_n) begin
            op_vld_q  <= vld_d;
            op_wr_q   <= wr_d;
            op_addr_q <= a_d;
            op_mask_q <= mask_d;
        end
    end

    assert_desel_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !asleep && !adv && cs_n) |=> !op_vld_q);

    assert_continue_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !asleep && adv && state_q == ST_WR) |=> (op_vld_q && op_wr_q));

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !asleep && adv && state_q != ST_DESEL) |=> (cnt_q == $past(cnt_q) + 2'd1));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(op_addr_q) && $stable(state_q) && $stable(op_vld_q)));
endmodule

// File: rtl/nwb_datapath.sv
module nwb_datapath #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             s1_vld,
    input  logic             s1_wr,
    input  logic [AW-1:0]    s1_addr,
    input  logic [LANES-1:0] s1_mask,
    input  logic [DW-1:0]    wdata,
    output logic             out_vld_q,
    output logic [DW-1:0]    out_dat_q
);
    logic             s2_vld, s2_wr;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s2_mask;
    logic [DW-1:0]    mem [DEPTH];

    // Pipeline stage two
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_mask <= '0;
        end else if (!cke_n) begin
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
        end
    end

    // Array write: data trails its address by two edges, lane by lane
    always_ff @(posedge clk) begin
        if (!cke_n && s2_vld && s2_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (s2_mask[l])
                    mem[s2_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Output register: read served at the same depth as writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            out_dat_q <= '0;
        end else if (!cke_n) begin
            out_vld_q <= s2_vld && !s2_wr;
            if (s2_vld && !s2_wr) out_dat_q <= mem[s2_addr];
        end
    end

    assert_rd_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_vld && !s2_wr) |=> out_vld_q);

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(out_dat_q) && $stable(out_vld_q)));
endmodule

// File: rtl/nwb_sram.sv
module nwb_sram #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             cs_n,
    input  logic             adv,
    input  logic             wr_n,
    input  logic [LANES-1:0] be_n,
    input  logic             burst_ilv,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    logic             asleep;
    logic             s1_vld, s1_wr;
    logic [AW-1:0]    s1_addr;
    logic [LANES-1:0] s1_mask;
    logic             out_vld;
    logic [DW-1:0]    out_dat;

    nwb_sleep_sync #(.STAGES(2)) u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .asleep(asleep)
    );

    nwb_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .asleep(asleep),
        .cs_n(cs_n), .adv(adv), .wr_n(wr_n), .be_n(be_n),
        .burst_ilv(burst_ilv), .addr(addr),
        .op_vld_q(s1_vld), .op_wr_q(s1_wr), .op_addr_q(s1_addr), .op_mask_q(s1_mask)
    );

    nwb_datapath #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
        .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_mask(s1_mask),
        .wdata(wdata), .out_vld_q(out_vld), .out_dat_q(out_dat)
    );

    // Asynchronous output gating
    always_comb begin
        rvalid = out_vld && !oe_n && !sleep && !asleep;
        rdata  = rvalid ? out_dat : '0;
    end
endmodule

// File: tb/nwb_sram_bench.sv
module nwb_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64, LANES = 4, LANE_W = 9;
    localparam int AW = $clog2(DEPTH), DW = LANES * LANE_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke_n = 1'b0, cs_n = 1'b1, adv = 1'b0, wr_n = 1'b1;
    logic [LANES-1:0] be_n = '1;
    logic burst_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    nwb_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_nwb_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .adv(adv),
        .wr_n(wr_n), .be_n(be_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct { logic ov; logic [DW-1:0] od; logic asl; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0, cyc_no = 0;
    string cur_req = "R1";
    bit mon_on = 0, done = 0;

    // Settings applied by the next cycle call
    logic g_oe_n = 1'b0, g_sleep = 1'b0, g_ilv = 1'b0;

    // Reference model
    logic [DW-1:0] refm [DEPTH];
    int m_state = 0;                  // 0 deselected, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0, m_sd = '0;
    logic s1v = 0, s1w = 0, s2v = 0, s2w = 0, m_ov = 0;
    logic [AW-1:0] s1a = '0, s2a = '0;
    logic [LANES-1:0] s1m = '0, s2m = '0;
    logic [DW-1:0] m_od = '0;

    task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int n);
        logic [8:0] c = n[8:0];
        return {c ^ 9'h1A5, c + 9'd77, ~c, c * 9'd3};
    endfunction

    // Driver: drives one cycle and pushes what the coming edge must produce
    task automatic cyc(input logic k, input logic c, input logic a, input logic w,
                       input logic [LANES-1:0] b, input logic [AW-1:0] ad);
        logic asl_now;
        logic nv, nw;
        logic [AW-1:0] na;
        logic [LANES-1:0] nm;
        logic [1:0] lo;
        exp_t e;
        @(negedge clk); #1;
        cyc_no++;
        cke_n = k; cs_n = c; adv = a; wr_n = w; be_n = b; addr = ad;
        wdata = pattern(cyc_no);
        oe_n = g_oe_n; sleep = g_sleep; burst_ilv = g_ilv;
        asl_now = m_sd[1];
        m_sd = {m_sd[0], g_sleep};
        if (!k) begin
            if (s2v && s2w) begin
                for (int l = 0; l < LANES; l++)
                    if (s2m[l]) refm[s2a][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
                m_ov = 0;
            end else if (s2v) begin
                m_ov = 1; m_od = refm[s2a];
            end else m_ov = 0;
            s2v = s1v; s2w = s1w; s2a = s1a; s2m = s1m;
            nv = 0; nw = 0; na = s1a; nm = '0;
            if (asl_now) m_state = 0;
            else if (!a) begin
                if (c) m_state = 0;
                else begin
                    m_base = ad; m_cnt = 0; m_state = w ? 1 : 2;
                    nv = 1; nw = !w; na = ad; nm = w ? '0 : ~b;
                end
            end else if (m_state != 0) begin
                m_cnt = m_cnt + 2'd1;
                lo = g_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
                na = {m_base[AW-1:2], lo};
                nv = 1; nw = (m_state == 2); nm = nw ? ~b : '0;
            end
            s1v = nv; s1w = nw; s1a = na; s1m = nm;
        end
        e.ov = m_ov; e.od = m_od; e.asl = m_sd[1];
        exp_q.push_back(e);
    endtask

    // Monitor: pops one expectation per cycle and compares the ports
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            logic ev;
            e = exp_q.pop_front();
            ev = e.ov && !oe_n && !sleep && !e.asl;
            check(rvalid == ev, "rvalid", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, ev});
            check(rdata == (ev ? e.od : '0), "rdata", rdata, ev ? e.od : '0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 1, '1, '0);
    endtask

    task automatic rd_burst(input logic [AW-1:0] a0, input int beats);
        cyc(0, 0, 0, 1, '1, a0);
        for (int i = 1; i < beats; i++) cyc(0, 0, 1, 1, '1, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        cur_req = "watchdog";
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) refm[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        check(rvalid == 1'b0, "reset rvalid", {{(DW-1){1'b0}}, rvalid}, '0);
        check(rdata == '0, "reset rdata", rdata, '0);
        rst_n = 1'b1;
        mon_on = 1;
        cur_req = "R1";
        cyc(0, 0, 1, 1, '1, '0);   // advance while deselected: no access
        cyc(0, 0, 1, 0, '0, '0);
        idle(3);

        // R5/R3: fill the whole array with linear write bursts, all lanes
        cur_req = "R5"; g_ilv = 0;
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc(0, 0, 0, 0, '0, AW'(b * 4));
            for (int i = 1; i < 4; i++) cyc(0, 0, 1, 0, '0, '0);
        end
        idle(3);

        // R5: linear read burst from an unaligned start, wrapping
        rd_burst(AW'(13), 4);
        idle(3);
        // R4: interleaved read bursts
        cur_req = "R4"; g_ilv = 1;
        rd_burst(AW'(22), 4);
        rd_burst(AW'(33), 4);
        rd_burst(AW'(7), 4);
        idle(3);

        // R3: lane-masked write and write abort
        cur_req = "R3"; g_ilv = 0;
        cyc(0, 0, 0, 0, 4'b1010, AW'(5));
        cyc(0, 0, 0, 0, 4'b1111, AW'(6));
        cyc(0, 0, 0, 0, 4'b0111, AW'(9));
        idle(2);
        rd_burst(AW'(5), 1); rd_burst(AW'(6), 1); rd_burst(AW'(9), 1);
        idle(3);

        // R9: read, write, read, write, read to one address, no bubbles
        cur_req = "R9";
        cyc(0, 0, 0, 1, '1, AW'(40));
        cyc(0, 0, 0, 0, '0, AW'(40));
        cyc(0, 0, 0, 1, '1, AW'(40));
        cyc(0, 0, 0, 0, 4'b1100, AW'(40));
        cyc(0, 0, 0, 1, '1, AW'(40));
        idle(3);

        // R7: deselecting load with write request, then R6 continue after it
        cur_req = "R7";
        cyc(0, 1, 0, 0, '0, AW'(41));
        cur_req = "R6";
        cyc(0, 0, 1, 0, '0, AW'(42));
        cyc(0, 0, 1, 0, '0, AW'(43));
        idle(2);
        rd_burst(AW'(40), 4);
        // R6: write burst continued with wr_n high still writes
        cyc(0, 0, 0, 0, '0, AW'(48));
        cyc(0, 0, 1, 1, '0, '0);
        cyc(0, 0, 1, 1, 4'b1110, '0);
        cyc(0, 0, 1, 1, '1, '0);
        idle(2);
        rd_burst(AW'(48), 4);
        idle(3);

        // R8: stall in the middle of a read burst
        cur_req = "R8";
        cyc(0, 0, 0, 1, '1, AW'(17));
        cyc(0, 0, 1, 1, '1, '0);
        cyc(1, 0, 0, 0, '0, AW'(60));
        cyc(1, 1, 0, 0, '0, AW'(61));
        cyc(1, 0, 1, 0, '0, AW'(62));
        cyc(0, 0, 1, 1, '1, '0);
        cyc(0, 0, 1, 1, '1, '0);
        // stall while a write waits for its data
        cyc(0, 0, 0, 0, '0, AW'(30));
        cyc(0, 1, 0, 1, '1, '0);
        cyc(1, 1, 0, 1, '1, '0);
        cyc(1, 1, 0, 1, '1, '0);
        idle(3);
        rd_burst(AW'(30), 1); rd_burst(AW'(60), 1);
        idle(3);

        // R11: output enable toggled during a read burst
        cur_req = "R11";
        rd_burst(AW'(24), 2);
        g_oe_n = 1;
        cyc(0, 0, 1, 1, '1, '0);
        g_oe_n = 0;
        cyc(0, 0, 1, 1, '1, '0);
        g_oe_n = 1;
        idle(2);
        g_oe_n = 0;
        idle(2);

        // R10: sleep entry and exit around read traffic
        cur_req = "R10";
        rd_burst(AW'(1), 4);
        g_sleep = 1;
        rd_burst(AW'(20), 4);
        cyc(0, 0, 0, 0, '0, AW'(21));
        rd_burst(AW'(2), 2);
        g_sleep = 0;
        rd_burst(AW'(3), 1);
        rd_burst(AW'(4), 1);
        rd_burst(AW'(21), 1);
        rd_burst(AW'(5), 2);
        idle(4);

        mon_on = 0;
        finish_run();
    end
endmodule